// File: doc/BRIEF.md
# Dual-Port Shared Memory with Mailbox Interrupts

This block is a byte-wide shared memory of 1024 locations that two processors reach through two fully independent ports, a left port and a right port. Each port has an active-low select, an active-low write enable (low for a write, high for a read), a 10-bit address, separate write-data and read-data buses, and an active-low interrupt output. Most locations are plain shared storage that either side may read or write.

The two highest words are message slots. Word 0x3FE belongs to the left processor and word 0x3FF belongs to the right processor. When one side writes a byte into the other side's slot, the byte is stored and the receiver's interrupt goes low. The interrupt stays low until the receiver reads its own slot, which returns the byte unchanged. The two sides use this to signal events such as "memory taken" or "memory released" with agreed codes. A side may not write its own slot.

Each interrupt is held by a two-state machine. It has the states FLAG_CLEAR (output high) and FLAG_RAISED (output low). The transition RAISE goes from FLAG_CLEAR to FLAG_RAISED when the peer writes the slot. The transition ACK goes from FLAG_RAISED to FLAG_CLEAR when the owner reads the slot and there is no peer write in the same cycle. Otherwise each state holds. Everything runs on one clock with a synchronous active-low reset.

Top module: `dual_port_mailbox_ram`

## Requirements
- R1: A byte written through either port to an ordinary address (0x000 to 0x3FD) is returned by a later read of that address from either port.
- R2: Read data appears on the port's read-data bus one clock after the read is presented. The bus holds its value in every cycle in which that port has no read.
- R3: While a port's select is high, that port changes no memory word and no interrupt flag.
- R4: A left-port write to 0x3FF drives the right interrupt low from the next clock and stores the byte. The codes 0xFF, 0x11, 0x88 and 0x55 are returned unchanged.
- R5: A right-port read of 0x3FF returns the stored byte and releases the right interrupt high from the next clock.
- R6: A right-port write to 0x3FE drives the left interrupt low. A left-port read of 0x3FE returns the byte and releases the left interrupt.
- R7: A raised interrupt stays low through any number of idle cycles and other accesses until its owner reads its own slot. Reads of the peer's slot do not clear it.
- R8: If the peer's write and the owner's read hit the same slot in one cycle, the interrupt stays low, the read returns the previous byte, and the new byte is kept.
- R9: A port's write to its own slot (left to 0x3FE, right to 0x3FF) is ignored. The stored byte is unchanged and no interrupt is raised.
- R10: When both ports write the same ordinary address in one cycle, the left port's byte is stored.
- R11: When one port reads and the other writes the same address in one cycle, the read returns the previous byte.
- R12: During and after reset, both interrupt outputs are high until a slot write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left write enable, low = write, high = read |
| l_addr | input | 10 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, registered |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right write enable, low = write, high = read |
| r_addr | input | 10 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, registered |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The hardest case to reach is the same-cycle collision on a slot. Here the peer's write (which would move the flag to FLAG_RAISED) lands in the same clock as the owner's acknowledging read (which would take the ACK transition). The bench first raises the flag with one code. It then drives both ports together in a single cycle, one writing a second code and the other reading the slot. It confirms that the read shows the first code and that the interrupt stays low. A following read then returns the second code and releases the interrupt. The bench uses the same lock-step drive of both ports to create the write-write and read-write collisions on ordinary addresses.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    parameter int unsigned DPR_ADDR_W = 10;
    parameter int unsigned DPR_DATA_W = 8;

    typedef enum logic {
        FLAG_CLEAR  = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

endpackage

// File: rtl/dpr_port_qual.sv
module dpr_port_qual #(
    parameter int unsigned ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] OWN_SLOT  = '0,
    parameter logic [ADDR_W-1:0] PEER_SLOT = '0
) (
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_en,
    output logic              wr_en,
    output logic              own_slot_rd,
    output logic              peer_slot_wr
);

    logic sel;

    always_comb begin
        sel          = ~cs_n;
        rd_en        = sel & we_n;
        // a port may never overwrite its own message slot
        wr_en        = sel & ~we_n & (addr != OWN_SLOT);
        own_slot_rd  = rd_en & (addr == OWN_SLOT);
        peer_slot_wr = wr_en & (addr == PEER_SLOT);
    end

endmodule

// File: rtl/dpr_mbox_flag.sv
module dpr_mbox_flag
    import dpr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise_i,
    input  logic ack_i,
    output logic irq_n
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLAG_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR:  if (raise_i)           state_d = FLAG_RAISED;
            FLAG_RAISED: if (ack_i && !raise_i) state_d = FLAG_CLEAR;
            default:                            state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        irq_n = (state_q != FLAG_RAISED);
    end

endmodule

// File: rtl/dpr_array.sv
module dpr_array #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_rd,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_rd,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // right first, left last: left wins a same-address collision
    always_ff @(posedge clk) begin
        if (r_wr) mem[r_addr] <= r_wdata;
        if (l_wr) mem[l_addr] <= l_wdata;
    end

    // registered reads see the word as it was before this edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_rdata <= '0;
            r_rdata <= '0;
        end else begin
            if (l_rd) l_rdata <= mem[l_addr];
            if (r_rd) r_rdata <= mem[r_addr];
        end
    end

endmodule

// File: rtl/dual_port_mailbox_ram.sv
module dual_port_mailbox_ram
    import dpr_pkg::*;
#(
    parameter int unsigned ADDR_W = DPR_ADDR_W,
    parameter int unsigned DATA_W = DPR_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_cs_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);

    localparam logic [ADDR_W-1:0] RIGHT_SLOT = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] LEFT_SLOT  = RIGHT_SLOT - 1'b1;

    logic l_rd, l_wr, l_ack, l_to_peer;
    logic r_rd, r_wr, r_ack, r_to_peer;

    dpr_port_qual #(
        .ADDR_W   (ADDR_W),
        .OWN_SLOT (LEFT_SLOT),
        .PEER_SLOT(RIGHT_SLOT)
    ) i_left_qual (
        .cs_n        (l_cs_n),
        .we_n        (l_we_n),
        .addr        (l_addr),
        .rd_en       (l_rd),
        .wr_en       (l_wr),
        .own_slot_rd (l_ack),
        .peer_slot_wr(l_to_peer)
    );

    dpr_port_qual #(
        .ADDR_W   (ADDR_W),
        .OWN_SLOT (RIGHT_SLOT),
        .PEER_SLOT(LEFT_SLOT)
    ) i_right_qual (
        .cs_n        (r_cs_n),
        .we_n        (r_we_n),
        .addr        (r_addr),
        .rd_en       (r_rd),
        .wr_en       (r_wr),
        .own_slot_rd (r_ack),
        .peer_slot_wr(r_to_peer)
    );

    dpr_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .l_rd   (l_rd),
        .l_wr   (l_wr),
        .l_addr (l_addr),
        .l_wdata(l_wdata),
        .l_rdata(l_rdata),
        .r_rd   (r_rd),
        .r_wr   (r_wr),
        .r_addr (r_addr),
        .r_wdata(r_wdata),
        .r_rdata(r_rdata)
    );

    // left interrupt: raised by the right port, acknowledged by the left
    dpr_mbox_flag i_left_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .raise_i(r_to_peer),
        .ack_i  (l_ack),
        .irq_n  (l_irq_n)
    );

    // right interrupt: raised by the left port, acknowledged by the right
    dpr_mbox_flag i_right_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .raise_i(l_to_peer),
        .ack_i  (r_ack),
        .irq_n  (r_irq_n)
    );

endmodule

// File: rtl/dpr_mailbox_chk.sv
module dpr_mailbox_chk #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_cs_n,
    input logic              l_we_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_irq_n,
    input logic              r_cs_n,
    input logic              r_we_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_irq_n
);

    localparam logic [ADDR_W-1:0] RS = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] LS = RS - 1'b1;

    logic l_read, r_read, l_post_r, r_post_l, l_take, r_take;

    always_comb begin
        l_read   = !l_cs_n && l_we_n;
        r_read   = !r_cs_n && r_we_n;
        l_post_r = !l_cs_n && !l_we_n && (l_addr == RS);
        r_post_l = !r_cs_n && !r_we_n && (r_addr == LS);
        l_take   = l_read && (l_addr == LS);
        r_take   = r_read && (r_addr == RS);
    end

    // R12
    irq_reset_chk: assert property (@(posedge clk) !rst_n |=> (l_irq_n && r_irq_n));

    // R4
    r_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_post_r |=> !r_irq_n);

    // R5
    r_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_take && !l_post_r |=> r_irq_n);

    // R6
    l_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_post_l |=> !l_irq_n);

    // R6
    l_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_take && !r_post_l |=> l_irq_n);

    // R7
    r_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_irq_n && !r_take |=> !r_irq_n);

    // R7
    l_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !l_irq_n && !l_take |=> !l_irq_n);

    // R9
    l_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_irq_n && !r_post_l |=> l_irq_n);

    // R9
    r_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_irq_n && !l_post_r |=> r_irq_n);

    // R2
    l_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !l_read |=> $stable(l_rdata));

    // R2
    r_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_read |=> $stable(r_rdata));

endmodule

bind dual_port_mailbox_ram dpr_mailbox_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) i_mailbox_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .l_cs_n (l_cs_n),
    .l_we_n (l_we_n),
    .l_addr (l_addr),
    .l_rdata(l_rdata),
    .l_irq_n(l_irq_n),
    .r_cs_n (r_cs_n),
    .r_we_n (r_we_n),
    .r_addr (r_addr),
    .r_rdata(r_rdata),
    .r_irq_n(r_irq_n)
);

// File: tb/test_dual_port_mailbox_ram.sv
module test_dual_port_mailbox_ram;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_cs_n = 1'b1, l_we_n = 1'b1;
    logic [9:0] l_addr = '0;
    logic [7:0] l_wdata = '0;
    logic [7:0] l_rdata;
    logic       l_irq_n;
    logic       r_cs_n = 1'b1, r_we_n = 1'b1;
    logic [9:0] r_addr = '0;
    logic [7:0] r_wdata = '0;
    logic [7:0] r_rdata;
    logic       r_irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dual_port_mailbox_ram i_dual_port_mailbox_ram (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock: drive at a falling edge, let the rising edge act, return at the next falling edge
    task automatic cyc(input logic lc, input logic lw, input logic [9:0] la, input logic [7:0] ld,
                       input logic rc, input logic rw, input logic [9:0] ra, input logic [7:0] rd);
        l_cs_n = lc; l_we_n = lw; l_addr = la; l_wdata = ld;
        r_cs_n = rc; r_we_n = rw; r_addr = ra; r_wdata = rd;
        @(negedge clk);
        l_cs_n = 1'b1; l_we_n = 1'b1; r_cs_n = 1'b1; r_we_n = 1'b1;
    endtask

    task automatic idle();                            cyc(1,1,0,0, 1,1,0,0); endtask
    task automatic lwr(input [9:0] a, input [7:0] d); cyc(0,0,a,d, 1,1,0,0); endtask
    task automatic lrd(input [9:0] a);                cyc(0,1,a,0, 1,1,0,0); endtask
    task automatic rwr(input [9:0] a, input [7:0] d); cyc(1,1,0,0, 0,0,a,d); endtask
    task automatic rrd(input [9:0] a);                cyc(1,1,0,0, 0,1,a,0); endtask

    task automatic t_reset();
        chk("R12 left irq after reset", l_irq_n, 1);
        chk("R12 right irq after reset", r_irq_n, 1);
    endtask

    task automatic t_plain();
        lwr(10'h010, 8'hA5);
        rrd(10'h010);
        chk("R1 right reads left write", r_rdata, 8'hA5);
        rwr(10'h020, 8'h3C);
        lrd(10'h020);
        chk("R1 left reads right write", l_rdata, 8'h3C);
        idle(); idle();
        chk("R2 left rdata holds", l_rdata, 8'h3C);
        chk("R2 right rdata holds", r_rdata, 8'hA5);
        lrd(10'h010);
        chk("R2 one-cycle read latency", l_rdata, 8'hA5);
    endtask

    task automatic t_select();
        cyc(1,0,10'h010,8'h00, 1,0,10'h010,8'h00);
        lrd(10'h010);
        chk("R3 deselected write ignored", l_rdata, 8'hA5);
        cyc(1,0,10'h3FF,8'h11, 1,0,10'h3FE,8'h11);
        chk("R3 deselected slot write no right irq", r_irq_n, 1);
        chk("R3 deselected slot write no left irq", l_irq_n, 1);
    endtask

    task automatic t_right_slot();
        logic [7:0] codes [4] = '{8'hFF, 8'h11, 8'h88, 8'h55};
        for (int i = 0; i < 4; i++) begin
            lwr(10'h3FF, codes[i]);
            chk("R4 right irq raised", r_irq_n, 0);
            idle(); idle(); idle();
            lrd(10'h3FF);
            rrd(10'h100);
            chk("R7 right irq held", r_irq_n, 0);
            rrd(10'h3FF);
            chk("R4 code passes through", r_rdata, codes[i]);
            chk("R5 right irq released", r_irq_n, 1);
        end
    endtask

    task automatic t_left_slot();
        rwr(10'h3FE, 8'h88);
        chk("R6 left irq raised", l_irq_n, 0);
        idle(); rrd(10'h3FE); lrd(10'h3FF);
        chk("R7 left irq held", l_irq_n, 0);
        lrd(10'h3FE);
        chk("R6 left reads code", l_rdata, 8'h88);
        chk("R6 left irq released", l_irq_n, 1);
    endtask

    task automatic t_set_wins();
        lwr(10'h3FF, 8'h55);
        cyc(0,0,10'h3FF,8'h88, 0,1,10'h3FF,8'h00);
        chk("R8 collided read sees old code", r_rdata, 8'h55);
        chk("R8 set wins, irq stays low", r_irq_n, 0);
        rrd(10'h3FF);
        chk("R8 new code kept", r_rdata, 8'h88);
        chk("R8 irq released afterwards", r_irq_n, 1);
    endtask

    task automatic t_own_slot();
        rwr(10'h3FE, 8'h11);
        lrd(10'h3FE);
        lwr(10'h3FE, 8'h77);
        chk("R9 left own-slot write raises nothing", l_irq_n, 1);
        lrd(10'h3FE);
        chk("R9 left own-slot word unchanged", l_rdata, 8'h11);
        rwr(10'h3FF, 8'h77);
        chk("R9 right own-slot write raises nothing", r_irq_n, 1);
        rrd(10'h3FF);
        chk("R9 right own-slot word unchanged", r_rdata, 8'h88);
    endtask

    task automatic t_collide();
        cyc(0,0,10'h040,8'h12, 0,0,10'h040,8'h34);
        rrd(10'h040);
        chk("R10 left wins same-address write", r_rdata, 8'h12);
    endtask

    task automatic t_read_write();
        lwr(10'h050, 8'h9A);
        cyc(0,0,10'h050,8'hBC, 0,1,10'h050,8'h00);
        chk("R11 read during write gives old", r_rdata, 8'h9A);
        cyc(0,1,10'h050,8'h00, 0,0,10'h050,8'hDE);
        chk("R11 left read during right write gives old", l_rdata, 8'hBC);
        rrd(10'h050);
        chk("R11 later read gives new", r_rdata, 8'hDE);
    endtask

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R12 left irq during reset", l_irq_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_select();
        t_right_slot();
        t_left_slot();
        t_set_wins();
        t_own_slot();
        t_collide();
        t_read_write();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule